// File: doc/BRIEF.md
# Processor Run-Control and Interrupt Unit

This block sits beside a small processor core and gives a host a word-addressed register window for starting, stopping and restarting that core, and for collecting its completion and fault notifications. A two-bit mode (a freeze bit and a software-reset bit) is held in a run-control register. Every write to that register is compared with the previous mode. Leaving the run state halts the core. Clearing software reset gives the core a one-cycle reset pulse and loads its program counter with a base address plus an offset field. Entering the run state releases the halt.

The core reports two events. A pause-complete event puts the core back into freeze plus software reset and flags completion. A breakpoint event freezes the core and flags completion together with an instruction fault. Four interrupt lines leave the block. Each line is the AND of a pending bit and an enable bit. The host clears pending bits by writing ones to the state register, and sets them by writing ones to the test register.

Top module: `coreRunCtl`

## Requirements
- R1: After reset, coreHalt is 1, the run-control register reads 0x3 (freeze and software reset both set, offset 0), pending and enable read 0, irqOut is 0, and coreResetPulse and pcLoad are 0.
- R2: irqOut[i] is 1 exactly when pending bit i and enable bit i are both 1. The bit order is: 0 host request, 1 finish, 2 instruction fault, 3 data fault.
- R3: A write to offset 0x00 clears each pending bit whose write-data bit [3:0] is 1 and leaves the other pending bits as they were.
- R4: A write to offset 0x08 sets each pending bit whose write-data bit [3:0] is 1. Offset 0x08 reads as 0. Offset 0x04 is a plain 4-bit enable register (bits [3:0]) whose upper bits read 0.
- R5: Offset 0x0C holds the mode in bits [1:0] (bit0 freeze, bit1 software reset; run means both are 0) and a 22-bit start offset in bits [23:2]. Bits [31:24] are dropped on write and read as 0.
- R6: A run-control write that moves the mode from run to a non-run value sets coreHalt in the following cycle.
- R7: A run-control write that changes software reset from 1 to 0 raises coreResetPulse and pcLoad for exactly one cycle. In that cycle pcValue equals BASE_ADDR plus the written bits [23:2] taken as an unsigned number.
- R8: A run-control write that moves the mode from non-run to run clears coreHalt in the following cycle, including in the same write that fires R7.
- R9: A pause-complete event sets coreHalt, sets the mode to 0x3, keeps the offset, and sets the finish pending bit.
- R10: A breakpoint event sets coreHalt, sets the mode to 0x1, and sets the finish and instruction-fault pending bits.
- R11: Reads from offsets other than 0x00, 0x04, 0x08 and 0x0C in the 4 KiB window return 0, and writes to them change nothing.
- R12: A run-control write in the same cycle as a core event has no effect. The event decides the mode and the halt, and no reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte address within the register window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| evtPause | input | 1 | Core pause-complete event, one cycle |
| evtBreak | input | 1 | Core breakpoint event, one cycle |
| coreHalt | output | 1 | Halt level to the core |
| coreResetPulse | output | 1 | One-cycle reset pulse to the core |
| pcLoad | output | 1 | Program counter load strobe |
| pcValue | output | 32 | Program counter value to load |
| irqOut | output | 4 | Interrupt levels (pending AND enable) |

## Verification
The bench builds the block with BASE_ADDR set to 0x2FF0_0000. With that base, adding the largest 22-bit offset carries across bit 20 and into the upper nibble, so an adder that is too narrow or mis-aligned shows up in pcValue. It drives offsets of 0x40 and 0x3FFFFF, the direct move from software reset to run that fires the reset and the resume together, and core events that arrive in the same cycle as run-control writes. It also writes junk to bits [31:24] to show that the top byte is dropped.

// File: rtl/rcPkg.sv
package rcPkg;
  localparam int DATA_W   = 32;
  localparam int NUM_IRQ  = 4;
  localparam int MODE_W   = 2;
  localparam int OFS_LSB  = 2;
  localparam int OFS_W    = 22;
  localparam int IDX_W    = 2;

  localparam logic [MODE_W-1:0] MODE_RUN    = 2'b00;
  localparam int                BIT_FREEZE  = 0;
  localparam int                BIT_SWRST   = 1;

  localparam int IRQ_HOST   = 0;
  localparam int IRQ_FINISH = 1;
  localparam int IRQ_IFAULT = 2;
  localparam int IRQ_DFAULT = 3;

  localparam logic [IDX_W-1:0] IDX_STATE  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_ENABLE = 2'd1;
  localparam logic [IDX_W-1:0] IDX_TEST   = 2'd2;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 2'd3;

  typedef struct packed {
    logic             wrState;
    logic             wrEnable;
    logic             wrTest;
    logic             wrCtrl;
    logic             haltSet;
    logic             haltClr;
    logic             resetFire;
    logic             takePause;
    logic             takeBreak;
    logic             rdValid;
    logic [IDX_W-1:0] rdIdx;
  } rcStrobeT;
endpackage

// File: rtl/rcControl.sv
module rcControl
  import rcPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [MODE_W-1:0] newMode,
  input  logic [MODE_W-1:0] curMode,
  input  logic              evtPause,
  input  logic              evtBreak,
  output rcStrobeT          strb
);
  localparam int HI_W = ADDR_W - OFS_LSB - IDX_W;

  logic             mapped;
  logic [IDX_W-1:0] idx;
  logic             anyEvt;
  logic             wrHit;
  logic             ctrlWr;
  logic [1:0]       unusedLow;

  assign unusedLow = busAddr[1:0];
  assign idx    = busAddr[OFS_LSB +: IDX_W];
  assign mapped = (busAddr[ADDR_W-1 -: HI_W] == '0);
  assign anyEvt = evtPause | evtBreak;
  assign wrHit  = busSel & busWrite & mapped;
  assign ctrlWr = wrHit & (idx == IDX_CTRL) & ~anyEvt;

  always_comb begin
    strb           = '0;
    strb.wrState   = wrHit & (idx == IDX_STATE);
    strb.wrEnable  = wrHit & (idx == IDX_ENABLE);
    strb.wrTest    = wrHit & (idx == IDX_TEST);
    strb.wrCtrl    = ctrlWr;
    strb.haltSet   = ctrlWr & (curMode == MODE_RUN) & (newMode != MODE_RUN);
    strb.haltClr   = ctrlWr & (curMode != MODE_RUN) & (newMode == MODE_RUN);
    strb.resetFire = ctrlWr & curMode[BIT_SWRST] & ~newMode[BIT_SWRST];
    strb.takeBreak = evtBreak;
    strb.takePause = evtPause & ~evtBreak;
    strb.rdValid   = busSel & ~busWrite & mapped;
    strb.rdIdx     = idx;
  end
endmodule

// File: rtl/rcDatapath.sv
module rcDatapath
  import rcPkg::*;
#(
  parameter logic [DATA_W-1:0] BASE_ADDR = 32'h0001_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  rcStrobeT           strb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [MODE_W-1:0]  curMode,
  output logic [DATA_W-1:0]  rdata,
  output logic               coreHalt,
  output logic               coreResetPulse,
  output logic               pcLoad,
  output logic [DATA_W-1:0]  pcValue,
  output logic [NUM_IRQ-1:0] irqOut
);
  localparam logic [NUM_IRQ-1:0] PAUSE_SET = NUM_IRQ'(1) << IRQ_FINISH;
  localparam logic [NUM_IRQ-1:0] BREAK_SET = (NUM_IRQ'(1) << IRQ_FINISH) |
                                             (NUM_IRQ'(1) << IRQ_IFAULT);
  localparam logic [MODE_W-1:0]  MODE_RST  = '1;
  localparam logic [MODE_W-1:0]  MODE_FRZ  = MODE_W'(1) << BIT_FREEZE;

  logic [NUM_IRQ-1:0] pendQ, pendNext, enQ;
  logic [MODE_W-1:0]  modeQ;
  logic [OFS_W-1:0]   ofsQ;
  logic [OFS_W-1:0]   ofsIn;
  logic [7:0]         unusedTop;

  assign ofsIn     = wdata[OFS_LSB +: OFS_W];
  assign unusedTop = wdata[DATA_W-1 -: 8];
  assign curMode   = modeQ;

  always_comb begin
    pendNext = pendQ;
    if (strb.wrState)   pendNext = pendNext & ~wdata[NUM_IRQ-1:0];
    if (strb.wrTest)    pendNext = pendNext | wdata[NUM_IRQ-1:0];
    if (strb.takePause) pendNext = pendNext | PAUSE_SET;
    if (strb.takeBreak) pendNext = pendNext | BREAK_SET;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ          <= '0;
      enQ            <= '0;
      modeQ          <= MODE_RST;
      ofsQ           <= '0;
      coreHalt       <= 1'b1;
      coreResetPulse <= 1'b0;
      pcLoad         <= 1'b0;
      pcValue        <= '0;
    end else begin
      pendQ          <= pendNext;
      coreResetPulse <= strb.resetFire;
      pcLoad         <= strb.resetFire;
      if (strb.wrEnable) enQ <= wdata[NUM_IRQ-1:0];
      if (strb.resetFire) pcValue <= BASE_ADDR + DATA_W'(ofsIn);
      if (strb.takeBreak) begin
        modeQ <= MODE_FRZ;
      end else if (strb.takePause) begin
        modeQ <= MODE_RST;
      end else if (strb.wrCtrl) begin
        modeQ <= wdata[MODE_W-1:0];
        ofsQ  <= ofsIn;
      end
      if (strb.takeBreak | strb.takePause | strb.haltSet) coreHalt <= 1'b1;
      else if (strb.haltClr)                              coreHalt <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : gIrq
    assign irqOut[i] = pendQ[i] & enQ[i];
  end

  always_comb begin
    rdata = '0;
    if (strb.rdValid) begin
      case (strb.rdIdx)
        IDX_STATE:  rdata = DATA_W'(pendQ);
        IDX_ENABLE: rdata = DATA_W'(enQ);
        IDX_CTRL:   rdata = DATA_W'({ofsQ, modeQ});
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/coreRunCtl.sv
module coreRunCtl
  import rcPkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
  parameter int          ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              evtPause,
  input  logic              evtBreak,
  output logic              coreHalt,
  output logic              coreResetPulse,
  output logic              pcLoad,
  output logic [31:0]       pcValue,
  output logic [3:0]        irqOut
);
  rcStrobeT          strb;
  logic [MODE_W-1:0] curMode;

  rcControl #(.ADDR_W(ADDR_W)) uCtl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .newMode  (busWdata[MODE_W-1:0]),
    .curMode  (curMode),
    .evtPause (evtPause),
    .evtBreak (evtBreak),
    .strb     (strb)
  );

  rcDatapath #(.BASE_ADDR(BASE_ADDR)) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .wdata          (busWdata),
    .curMode        (curMode),
    .rdata          (busRdata),
    .coreHalt       (coreHalt),
    .coreResetPulse (coreResetPulse),
    .pcLoad         (pcLoad),
    .pcValue        (pcValue),
    .irqOut         (irqOut)
  );
endmodule

// File: rtl/rcChecker.sv
module rcChecker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              evtPause,
  input logic              evtBreak,
  input logic              coreHalt,
  input logic              coreResetPulse,
  input logic              pcLoad,
  input logic [3:0]        irqOut
);
  logic ctrlWrNoEvt, enWrZero;
  assign ctrlWrNoEvt = busSel && busWrite && (busAddr[ADDR_W-1:2] == 'd3) && !evtPause && !evtBreak;
  assign enWrZero    = busSel && busWrite && (busAddr[ADDR_W-1:2] == 'd1) && (busWdata[3:0] == 4'd0);

  // R7: reset pulse lasts one cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    coreResetPulse |=> !coreResetPulse);

  // R7: a PC load follows an event-free control write clearing software reset
  a_r7_load_source: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> $past(ctrlWrNoEvt && !busWdata[1]));

  // R8: writing run mode releases the halt
  a_r8_run_release: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrNoEvt && busWdata[1:0] == 2'b00) |=> !coreHalt);

  // R9: pause-complete halts the core
  a_r9_pause_halts: assert property (@(posedge clk) disable iff (!rstN)
    evtPause |=> coreHalt);

  // R10: breakpoint halts the core and raises no reset pulse
  a_r10_break_halts: assert property (@(posedge clk) disable iff (!rstN)
    evtBreak |=> (coreHalt && !coreResetPulse));

  // R2: all-zero enable masks every interrupt line
  a_r2_mask_zero: assert property (@(posedge clk) disable iff (!rstN)
    enWrZero |=> (irqOut == 4'd0));
endmodule

bind coreRunCtl rcChecker #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_coreRunCtl.sv
module sim_coreRunCtl;
  localparam logic [31:0] BASE = 32'h2FF0_0000;

  typedef struct packed {
    logic        isWr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  expIrq;
    logic [7:0]  req;
  } rowT;

  // data = write data for writes, expected read data for reads
  localparam rowT TBL [0:14] = '{
    '{1'b0, 12'h00C, 32'h0000_0003, 4'h0, 8'd5},  // R5 reset mode readback
    '{1'b0, 12'h000, 32'h0000_0000, 4'h0, 8'd3},  // R3 nothing pending
    '{1'b1, 12'h008, 32'h0000_000F, 4'h0, 8'd4},  // R4 test sets all
    '{1'b0, 12'h000, 32'h0000_000F, 4'h0, 8'd4},  // R4
    '{1'b1, 12'h004, 32'hFFFF_FFF5, 4'h5, 8'd2},  // R2 enable 0101
    '{1'b0, 12'h004, 32'h0000_0005, 4'h5, 8'd4},  // R4 upper bits dropped
    '{1'b1, 12'h000, 32'h0000_0003, 4'h4, 8'd3},  // R3 clear bits 0,1
    '{1'b0, 12'h000, 32'h0000_000C, 4'h4, 8'd3},  // R3
    '{1'b1, 12'h010, 32'hFFFF_FFFF, 4'h4, 8'd11}, // R11 unmapped write
    '{1'b0, 12'h010, 32'h0000_0000, 4'h4, 8'd11}, // R11 unmapped read
    '{1'b0, 12'h000, 32'h0000_000C, 4'h4, 8'd11}, // R11 state untouched
    '{1'b0, 12'hFFC, 32'h0000_0000, 4'h4, 8'd11}, // R11 top of window
    '{1'b0, 12'h008, 32'h0000_0000, 4'h4, 8'd4},  // R4 test reads zero
    '{1'b1, 12'h004, 32'h0000_000A, 4'h8, 8'd2},  // R2 enable 1010
    '{1'b1, 12'h000, 32'h0000_000F, 4'h0, 8'd3}   // R3 clear all
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evtPause = 1'b0, evtBreak = 1'b0;
  logic        coreHalt, coreResetPulse, pcLoad;
  logic [31:0] pcValue;
  logic [3:0]  irqOut;
  int          nTests = 0, nFails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  coreRunCtl #(.BASE_ADDR(BASE), .ADDR_W(12)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d,
                       input logic p = 1'b0, input logic b = 1'b0);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    evtPause = p; evtBreak = b;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; evtPause = 1'b0; evtBreak = 1'b0;
  endtask

  task automatic event1(input logic p, input logic b);
    @(negedge clk);
    evtPause = p; evtBreak = b;
    @(negedge clk);
    evtPause = 1'b0; evtBreak = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic strobes(input string req, input logic h, input logic pulse);
    check({req, " halt"}, 32'(coreHalt), 32'(h));
    check({req, " resetPulse"}, 32'(coreResetPulse), 32'(pulse));
    check({req, " pcLoad"}, 32'(pcLoad), 32'(pulse));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    strobes("R1", 1'b1, 1'b0);
    check("R1 irq", 32'(irqOut), 32'h0);
    busRd(12'h004, rd); check("R1 enable", rd, 32'h0);

    for (int i = 0; i < 15; i++) begin
      if (TBL[i].isWr) begin
        busWr(TBL[i].addr, TBL[i].data);
      end else begin
        busRd(TBL[i].addr, rd);
        check($sformatf("R%0d row %0d read", TBL[i].req, i), rd, TBL[i].data);
      end
      check($sformatf("R%0d row %0d irq", TBL[i].req, i), 32'(irqOut), 32'(TBL[i].expIrq));
    end

    // R5 top byte dropped, mode stays reset+freeze
    busWr(12'h00C, 32'hFF00_0107);
    strobes("R5", 1'b1, 1'b0);
    busRd(12'h00C, rd); check("R5 ctrl readback", rd, 32'h0000_0107);

    // R7 software reset released, freeze held
    busWr(12'h00C, 32'h0000_0101);
    strobes("R7", 1'b1, 1'b1);
    check("R7 pcValue", pcValue, BASE + 32'h40);
    @(negedge clk);
    strobes("R7 single cycle", 1'b1, 1'b0);

    // R8 resume
    busWr(12'h00C, 32'h0000_0100);
    strobes("R8", 1'b0, 1'b0);
    // R6 run -> freeze
    busWr(12'h00C, 32'h0000_0005);
    strobes("R6", 1'b1, 1'b0);
    busRd(12'h00C, rd); check("R6 ctrl readback", rd, 32'h0000_0005);
    busWr(12'h00C, 32'h0000_0000);
    strobes("R8 again", 1'b0, 1'b0);
    busWr(12'h00C, 32'h00FF_FFFE);
    strobes("R6 to swreset", 1'b1, 1'b0);
    // R7 + R8 in the same write, largest offset
    busWr(12'h00C, 32'h00FF_FFFC);
    strobes("R7 R8 combined", 1'b0, 1'b1);
    check("R7 pcValue max", pcValue, BASE + 32'h003F_FFFF);

    // R9 pause-complete
    busWr(12'h004, 32'h0000_000F);
    event1(1'b1, 1'b0);
    strobes("R9", 1'b1, 1'b0);
    check("R9 irq", 32'(irqOut), 32'h2);
    busRd(12'h00C, rd); check("R9 ctrl", rd, 32'h00FF_FFFF);

    // R10 breakpoint
    busWr(12'h000, 32'h0000_000F);
    busWr(12'h00C, 32'h0000_0000);
    strobes("R10 prep", 1'b0, 1'b1);
    event1(1'b0, 1'b1);
    strobes("R10", 1'b1, 1'b0);
    check("R10 irq", 32'(irqOut), 32'h6);
    busRd(12'h00C, rd); check("R10 ctrl", rd, 32'h0000_0001);

    // R12 event beats a simultaneous control write
    busWr(12'h000, 32'h0000_000F);
    busWr(12'h00C, 32'h0000_0000);
    strobes("R12 prep", 1'b0, 1'b0);
    busWr(12'h00C, 32'h0000_0202, 1'b0, 1'b1);
    strobes("R12 break", 1'b1, 1'b0);
    busRd(12'h00C, rd); check("R12 break ctrl", rd, 32'h0000_0001);
    busWr(12'h00C, 32'h0000_0000, 1'b1, 1'b0);
    strobes("R12 pause", 1'b1, 1'b0);
    busRd(12'h00C, rd); check("R12 pause ctrl", rd, 32'h0000_0003);
    check("R12 irq", 32'(irqOut), 32'h6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule